// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two radix-2 signed-digit numbers in a single combinational stage. Each digit is -1, 0 or +1 and travels on three wires, exactly one of which is high. An operand of `DIGITS` digits is therefore a vector three times that wide. The sum has one more digit than the operands.

Every digit position forms an intermediate digit and a transfer digit from its own pair of input digits. To make that choice it also looks at one fact about the pair below: whether that pair holds a negative digit. Each output digit is the intermediate digit plus the transfer arriving from the position below. No transfer ever moves further than one position, so the delay does not grow with the operand width.

Any input digit that is not a legal code raises an error flag. The sum has no defined value while the flag is high. The block is used as the adder cell of partial-product accumulation trees that need a fixed delay whatever the width.

Top module: `sd_carryfree_adder`

## Requirements
- R1: Digit codes are, from bit 2 down to bit 0: -1 = 100, 0 = 010, +1 = 001. Digit i occupies bits 3i+2..3i and has weight 2^i. For legal inputs, the value of the (DIGITS+1)-digit sum equals the value of A plus the value of B.
- R2: While the error flag is low, every output digit is one of the three legal codes.
- R3: The error flag is high exactly when at least one digit of either operand has a number of set bits other than one.
- R4: A digit pair that sums to -2, 0 or +2 gives intermediate digit 0 and transfer -1, 0 or +1 respectively. For example, -1 plus -1 at digit 0, with zeros elsewhere, gives S0 = 0 and S1 = -1.
- R5: A digit pair that sums to ±1 looks at the pair below. If that pair holds a negative digit, a sum of +1 gives intermediate +1 and transfer 0, and a sum of -1 gives intermediate +1 and transfer -1. Otherwise a sum of +1 gives intermediate -1 and transfer +1, and a sum of -1 gives intermediate -1 and transfer 0.
- R6: At position 0 the pair below counts as non-negative and the incoming transfer is 0. So +1 plus 0 there gives S0 = -1 and S1 = +1, and an even pair sum there gives S0 = 0.
- R7: The top output digit, at position DIGITS, equals the transfer out of position DIGITS-1. With both operands all +1, the sum is 0 at digit 0 and +1 at every other digit. With both operands all -1, the sum is 0 at digit 0 and -1 at every other digit.
- R8: Changing the input digits at position k can change only output digits k, k+1 and k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 3*DIGITS | Operand A, one three-wire code per digit |
| b_i | input | 3*DIGITS | Operand B, one three-wire code per digit |
| sum_o | output | 3*(DIGITS+1) | Sum, one three-wire code per digit |
| code_err_o | output | 1 | High when any operand digit is not a legal code |

## Verification
The bound checker watches the value identity between operands and sum, the legality of every output digit, and the agreement of the error flag with an independent one-hot test of the inputs. It also checks two local facts: the top digit when both top digits match, and the zero low digit for an even low pair. These hold on every input change. Only the bench scenarios can show the exact digit patterns that the per-position rules produce. Likewise, only the bench can show that an input change stays within three output positions, since both need a chosen pair of stimuli and a comparison between them. The bench also runs every input pair of a three-digit instance.

// File: rtl/sd_carryfree_adder.sv
module sd_carryfree_adder #(
  parameter int DIGITS = 8
) (
  input  logic [3*DIGITS-1:0]     a_i,
  input  logic [3*DIGITS-1:0]     b_i,
  output logic [3*(DIGITS+1)-1:0] sum_o,
  output logic                    code_err_o
);

  logic [DIGITS-1:0] bad;
  logic [DIGITS-1:0] pair_neg;
  logic [DIGITS:0]   xfer_neg;
  logic [DIGITS:0]   xfer_pos;

  assign xfer_neg[0] = 1'b0;
  assign xfer_pos[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_pos
    logic [2:0] x, y;
    logic below_neg;
    logic m2, p2, m1, p1, odd;
    logic u_neg, u_pos, u_zero, c_zero;

    assign x = a_i[3*g +: 3];
    assign y = b_i[3*g +: 3];

    assign bad[g]      = ~((x[0] ^ x[1] ^ x[2]) & ~(&x)) | ~((y[0] ^ y[1] ^ y[2]) & ~(&y));
    assign pair_neg[g] = x[2] | y[2];

    if (g == 0) begin : g_lsb
      assign below_neg = 1'b0;
    end else begin : g_mid
      assign below_neg = pair_neg[g-1];
    end

    assign m2  = x[2] & y[2];
    assign p2  = x[0] & y[0];
    assign m1  = (x[2] & y[1]) | (x[1] & y[2]);
    assign p1  = (x[0] & y[1]) | (x[1] & y[0]);
    assign odd = m1 | p1;

    assign u_pos  = odd & below_neg;
    assign u_neg  = odd & ~below_neg;
    assign u_zero = ~odd;

    assign xfer_neg[g+1] = m2 | (m1 & below_neg);
    assign xfer_pos[g+1] = p2 | (p1 & ~below_neg);

    assign c_zero = ~(xfer_neg[g] | xfer_pos[g]);

    assign sum_o[3*g+2] = (u_neg & c_zero) | (u_zero & xfer_neg[g]);
    assign sum_o[3*g+0] = (u_pos & c_zero) | (u_zero & xfer_pos[g]);
    assign sum_o[3*g+1] = (u_zero & c_zero) | (u_neg & xfer_pos[g]) | (u_pos & xfer_neg[g]);
  end

  assign sum_o[3*DIGITS+2] = xfer_neg[DIGITS];
  assign sum_o[3*DIGITS+1] = ~(xfer_neg[DIGITS] | xfer_pos[DIGITS]);
  assign sum_o[3*DIGITS+0] = xfer_pos[DIGITS];

  assign code_err_o = |bad;

endmodule

// File: rtl/sd_carryfree_adder_chk.sv
module sd_carryfree_adder_chk #(
  parameter int DIGITS = 8
) (
  input logic [3*DIGITS-1:0]     a_i,
  input logic [3*DIGITS-1:0]     b_i,
  input logic [3*(DIGITS+1)-1:0] sum_o,
  input logic                    code_err_o
);

  longint va, vb, vs;
  logic   in_ok, out_ok;

  function automatic longint dval(input logic [2:0] c);
    return c[0] ? 64'sd1 : (c[2] ? -64'sd1 : 64'sd0);
  endfunction

  always_comb begin
    va = 0; vb = 0; vs = 0;
    in_ok = 1'b1; out_ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      va += dval(a_i[3*i +: 3]) * (64'sd1 <<< i);
      vb += dval(b_i[3*i +: 3]) * (64'sd1 <<< i);
      if (!$onehot(a_i[3*i +: 3]) || !$onehot(b_i[3*i +: 3])) in_ok = 1'b0;
    end
    for (int i = 0; i <= DIGITS; i++) begin
      vs += dval(sum_o[3*i +: 3]) * (64'sd1 <<< i);
      if (!$onehot(sum_o[3*i +: 3])) out_ok = 1'b0;
    end
  end

  always_comb begin
    // R1
    value_match_chk: assert (!in_ok || vs == va + vb) else $error("sum value mismatch");
    // R2
    digit_legal_chk: assert (!in_ok || out_ok) else $error("illegal output digit");
    // R3
    err_flag_chk: assert (code_err_o == !in_ok) else $error("error flag wrong");
    // R7
    top_digit_chk: assert (!in_ok || a_i[3*DIGITS-1 -: 3] != b_i[3*DIGITS-1 -: 3] || a_i[3*DIGITS-2]
                           || sum_o[3*DIGITS +: 3] == a_i[3*DIGITS-1 -: 3]) else $error("top digit wrong");
    // R6
    low_digit_chk: assert (!in_ok || (a_i[1] ^ b_i[1]) || sum_o[2:0] == 3'b010) else $error("low digit wrong");
  end

endmodule

bind sd_carryfree_adder sd_carryfree_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .code_err_o(code_err_o)
);

// File: tb/sd_carryfree_adder_bench.sv
module sd_carryfree_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3*N-1:0]      a, b;
  logic [3*(N+1)-1:0]  s;
  logic                err;
  logic [3*NS-1:0]     sa, sb;
  logic [3*(NS+1)-1:0] ss;
  logic                serr;

  int checks = 0, errors = 0;
  bit done = 0;

  sd_carryfree_adder #(.DIGITS(N)) u_sd_carryfree_adder (.a_i(a), .b_i(b), .sum_o(s), .code_err_o(err));
  sd_carryfree_adder #(.DIGITS(NS)) u_small (.a_i(sa), .b_i(sb), .sum_o(ss), .code_err_o(serr));

  function automatic logic [2:0] enc(input int d);
    return d < 0 ? 3'b100 : (d > 0 ? 3'b001 : 3'b010);
  endfunction

  function automatic longint dec(input logic [89:0] v, input int nd, output bit legal);
    longint r = 0;
    legal = 1;
    for (int i = 0; i < nd; i++) begin
      case (v[3*i +: 3])
        3'b100: r -= (64'sd1 <<< i);
        3'b010: ;
        3'b001: r += (64'sd1 <<< i);
        default: legal = 0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [89:0] rnd_vec(input int nd);
    logic [89:0] v = '0;
    for (int i = 0; i < nd; i++) v[3*i +: 3] = enc(int'($urandom % 3) - 1);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3*N-1:0] x, input logic [3*N-1:0] y);
    @(posedge clk);
    a = x; b = y;
    @(negedge clk);
  endtask

  function automatic logic [3*N-1:0] digits(input int d0, input int d1, input int d2);
    logic [3*N-1:0] v;
    for (int i = 0; i < N; i++) v[3*i +: 3] = 3'b010;
    v[2:0] = enc(d0); v[5:3] = enc(d1); v[8:6] = enc(d2);
    return v;
  endfunction

  function automatic logic [3*(N+1)-1:0] sdigits(input int d0, input int d1, input int d2);
    logic [3*(N+1)-1:0] v;
    for (int i = 0; i <= N; i++) v[3*i +: 3] = 3'b010;
    v[2:0] = enc(d0); v[5:3] = enc(d1); v[8:6] = enc(d2);
    return v;
  endfunction

  task automatic t_zero;
    apply(digits(0,0,0), digits(0,0,0));
    chk(s == sdigits(0,0,0), "R1 zero operands", longint'(s), longint'(sdigits(0,0,0)));
    chk(err == 1'b0, "R3 no error on zeros", longint'(err), 0);
  endtask

  task automatic t_rules;
    apply(digits(-1,0,0), digits(-1,0,0));
    chk(s == sdigits(0,-1,0), "R4 pair -2", longint'(s), longint'(sdigits(0,-1,0)));
    apply(digits(1,0,0), digits(-1,0,0));
    chk(s == sdigits(0,0,0), "R4 pair 0", longint'(s), longint'(sdigits(0,0,0)));
    apply(digits(1,0,0), digits(1,0,0));
    chk(s == sdigits(0,1,0), "R4 pair +2", longint'(s), longint'(sdigits(0,1,0)));
    apply(digits(-1,1,0), digits(0,0,0));
    chk(s == sdigits(-1,1,0), "R5 +1 over negative", longint'(s), longint'(sdigits(-1,1,0)));
    apply(digits(-1,-1,0), digits(0,0,0));
    chk(s == sdigits(-1,1,-1), "R5 -1 over negative", longint'(s), longint'(sdigits(-1,1,-1)));
    apply(digits(1,1,0), digits(0,0,0));
    chk(s == sdigits(-1,0,1), "R5 +1 over non-negative", longint'(s), longint'(sdigits(-1,0,1)));
  endtask

  task automatic t_lsb;
    apply(digits(1,0,0), digits(0,0,0));
    chk(s == sdigits(-1,1,0), "R6 +1 at digit 0", longint'(s), longint'(sdigits(-1,1,0)));
    apply(digits(-1,0,0), digits(0,0,0));
    chk(s == sdigits(-1,0,0), "R6 -1 at digit 0", longint'(s), longint'(sdigits(-1,0,0)));
  endtask

  task automatic t_top;
    logic [3*N-1:0] p, m;
    logic [3*(N+1)-1:0] ep, em;
    for (int i = 0; i < N; i++) begin p[3*i +: 3] = 3'b001; m[3*i +: 3] = 3'b100; end
    for (int i = 0; i <= N; i++) begin ep[3*i +: 3] = 3'b001; em[3*i +: 3] = 3'b100; end
    ep[2:0] = 3'b010; em[2:0] = 3'b010;
    apply(p, p);
    chk(s == ep, "R7 all +1", longint'(s), longint'(ep));
    apply(m, m);
    chk(s == em, "R7 all -1", longint'(s), longint'(em));
  endtask

  task automatic t_random;
    for (int it = 0; it < 300; it++) begin
      logic [89:0] x, y;
      bit lx, ly, ls;
      longint vx, vy, vs;
      x = rnd_vec(N); y = rnd_vec(N);
      apply(x[3*N-1:0], y[3*N-1:0]);
      vx = dec(x, N, lx); vy = dec(y, N, ly); vs = dec({63'b0, s}, N+1, ls);
      chk(vs == vx + vy && err == 1'b0, "R1 random value", vs, vx + vy);
      chk(ls, "R2 random digit legality", longint'(s), 0);
    end
  endtask

  task automatic t_exhaustive;
    for (int i = 0; i < 27; i++) begin
      for (int j = 0; j < 27; j++) begin
        logic [89:0] x = '0, y = '0;
        bit lx, ly, ls;
        longint vs;
        int ti = i, tj = j;
        for (int d = 0; d < NS; d++) begin
          x[3*d +: 3] = enc(ti % 3 - 1); ti /= 3;
          y[3*d +: 3] = enc(tj % 3 - 1); tj /= 3;
        end
        @(posedge clk);
        sa = x[3*NS-1:0]; sb = y[3*NS-1:0];
        @(negedge clk);
        vs = dec({78'b0, ss}, NS+1, ls);
        chk(ls && serr == 1'b0 && vs == dec(x, NS, lx) + dec(y, NS, ly),
            "R1 R2 exhaustive small", vs, dec(x, NS, lx) + dec(y, NS, ly));
      end
    end
  endtask

  task automatic t_err;
    logic [2:0] badc [4] = '{3'b000, 3'b011, 3'b111, 3'b110};
    for (int k = 0; k < 4; k++) begin
      logic [89:0] x, y;
      int pos = k * 2 + 1;
      x = rnd_vec(N); y = rnd_vec(N);
      if (k[0]) x[3*pos +: 3] = badc[k]; else y[3*pos +: 3] = badc[k];
      apply(x[3*N-1:0], y[3*N-1:0]);
      chk(err == 1'b1, "R3 illegal code flagged", longint'(err), 1);
    end
  endtask

  task automatic t_local;
    for (int k = 0; k < N; k++) begin
      logic [89:0] x, y;
      logic [3*(N+1)-1:0] s0;
      bit same = 1;
      x = rnd_vec(N); y = rnd_vec(N);
      apply(x[3*N-1:0], y[3*N-1:0]);
      s0 = s;
      x[3*k +: 3] = (x[3*k +: 3] == 3'b001) ? 3'b100 : 3'b001;
      y[3*k +: 3] = (y[3*k +: 3] == 3'b010) ? 3'b100 : 3'b010;
      apply(x[3*N-1:0], y[3*N-1:0]);
      for (int j = 0; j <= N; j++)
        if ((j < k || j > k + 2) && s[3*j +: 3] != s0[3*j +: 3]) same = 0;
      chk(same, "R8 change confined to three digits", longint'(s), longint'(s0));
    end
  endtask

  initial begin
    a = '0; b = '0; sa = '0; sb = '0;
    t_zero;
    t_rules;
    t_lsb;
    t_top;
    t_random;
    t_exhaustive;
    t_err;
    t_local;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule